// File: doc/BRIEF.md
# Quarter-Pel Bicubic Motion Interpolator

This block builds one 8x8 block of motion-compensated luma samples at a fractional position. The horizontal and vertical offsets are each given in quarter pixels, from 0 to 3. The caller streams in a reference window of 11 rows by 11 pixels. The window covers one source row above the block and two below it, and one source column left of the block and two right of it. The caller also gives a rounding bit, the two offset codes and a select between writing and averaging. The filter phase is chosen for each direction: code 1 is the quarter position, code 2 the half position and code 3 the three-quarter position.

When only one offset is non-zero, a single four-tap filter runs along that direction. When both are non-zero, the block first filters vertically into a signed 16-bit intermediate array of 8 rows by 11 columns. It then filters that array horizontally. Results are clamped to 8 bits. In average mode each result is blended with the caller's current destination row, which the caller presents on `dst_row` while that output row is valid.

Top module: `qpel_bicubic`

## Requirements
- R1: `in_ready` is high only while the block is collecting rows. A row is taken on a clock edge where `in_valid` and `in_ready` are both high, and exactly 11 rows make a window. Row j of the window holds source row j-1. Pixel k of a row sits in bits [8k+7:8k] and holds source column k-1. Rows offered while `in_ready` is low are ignored.
- R2: `hmode`, `vmode`, `rnd` and `avg_mode` are captured with the first row of a window. Values driven with later rows have no effect on the block.
- R3: With one non-zero offset, `out_valid` rises in the cycle after the 11th row is taken. With two non-zero offsets it rises 9 cycles after. Eight rows then follow on consecutive cycles, top row first. `done` is high together with the 8th row, and `in_ready` is high again in the next cycle.
- R4: For half-pel filtering in one direction, the taps are -1, 9, 9, -1 on source offsets -1, 0, +1, +2. The block adds 8-r and shifts right by 4.
- R5: For code 1 in one direction, the taps are -4, 53, 18, -3 on offsets -1, 0, +1, +2. Code 3 uses the mirrored taps -3, 18, 53, -4. The block adds 32-r and shifts right by 6.
- R6: Horizontal-only filtering uses r = `rnd`. Vertical-only filtering uses r = 1 - `rnd`.
- R7: In two-pass filtering, the vertical pass runs on all 11 columns. Code weights are 0, 5, 1, 5 for codes 0 to 3. The pass shifts arithmetically right by s = (weight(h)+weight(v))>>1 after adding (1<<(s-1)) + `rnd` - 1. Each result fits in signed 16 bits.
- R8: In two-pass filtering, the horizontal pass applies the `hmode` taps to the intermediate values. It adds 64 - `rnd` and shifts arithmetically right by 7.
- R9: Every final filtered value is clamped to the range 0 to 255.
- R10: With `avg_mode` set, each output pixel is (f + d + 1) >> 1. Here f is the filtered pixel and d is the matching pixel of `dst_row`.
- R11: With both offsets 0, each output pixel equals the source pixel at its own position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window row offered |
| in_ready | output | 1 | Block is collecting window rows |
| in_row | input | 88 | One window row, 11 pixels, leftmost in low bits |
| hmode | input | 2 | Horizontal offset in quarter pixels |
| vmode | input | 2 | Vertical offset in quarter pixels |
| rnd | input | 1 | Rounding-control bit |
| avg_mode | input | 1 | 1 = average with destination, 0 = write |
| dst_row | input | 64 | Current destination row, used in average mode |
| out_valid | output | 1 | Output row valid |
| out_row | output | 64 | Eight output pixels, leftmost in low bits |
| done | output | 1 | High with the last row of the block |

## Verification
The bench counts cycles from the edge that takes the 11th row. It expects the first output row at the next sampling point for one-direction filtering, and 9 sampling points later for two-pass filtering. The eight rows are then compared on consecutive cycles, and `done` is expected only on the eighth. The bench samples every output on the falling edge and drives `dst_row` before it reads the averaged result. Every check therefore lands in the cycle the register path makes due. `in_ready` is checked low at every sampling point between the last accepted row and `done`.

// File: rtl/qpel_bicubic.sv
`timescale 1ns/1ps
module qpel_bicubic #(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int SUM_W = 24,
  parameter int MID_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [(BLK+3)*PIX_W-1:0]   in_row,
  input  logic [1:0]                 hmode,
  input  logic [1:0]                 vmode,
  input  logic                       rnd,
  input  logic                       avg_mode,
  input  logic [BLK*PIX_W-1:0]       dst_row,
  output logic                       out_valid,
  output logic [BLK*PIX_W-1:0]       out_row,
  output logic                       done
);
  localparam int WIN     = BLK + 3;
  localparam int CW      = $clog2(WIN);
  localparam int RW      = $clog2(BLK);
  localparam int PMAX    = (1 << PIX_W) - 1;
  localparam int MID_MAX = (1 << (MID_W-1)) - 1;
  localparam int MID_MIN = -(1 << (MID_W-1));

  typedef enum logic [1:0] {S_LOAD, S_VERT, S_OUT} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [RW-1:0]    ry;
  logic [1:0]       h_q, v_q;
  logic             rnd_q, avg_q, two_q;
  logic [PIX_W-1:0] win  [WIN][WIN];
  logic signed [MID_W-1:0] mid [BLK][WIN];
  logic [PIX_W-1:0] vrow [4][WIN];
  logic signed [SUM_W-1:0] mval [WIN];
  logic signed [SUM_W-1:0] mid_bias;
  int               mid_sh;

  function automatic logic signed [SUM_W-1:0] fir4(input logic [1:0] m,
      input logic signed [SUM_W-1:0] a, input logic signed [SUM_W-1:0] b,
      input logic signed [SUM_W-1:0] c, input logic signed [SUM_W-1:0] d);
    case (m)
      2'd1:    return SUM_W'(-4*a + 53*b + 18*c - 3*d);
      2'd2:    return SUM_W'(-a + 9*b + 9*c - d);
      2'd3:    return SUM_W'(-3*a + 18*b + 53*c - 4*d);
      default: return SUM_W'(64*b);
    endcase
  endfunction

  function automatic logic signed [SUM_W-1:0] bias1(input logic [1:0] m, input logic r);
    return (m == 2'd2) ? SUM_W'(8 - int'(r)) : SUM_W'(32 - int'(r));
  endfunction

  function automatic int sh1(input logic [1:0] m);
    return (m == 2'd2) ? 4 : 6;
  endfunction

  function automatic int wgt(input logic [1:0] m);
    case (m)
      2'd1, 2'd3: return 5;
      2'd2:       return 1;
      default:    return 0;
    endcase
  endfunction

  assign in_ready  = (st == S_LOAD);
  assign out_valid = (st == S_OUT);
  assign done      = out_valid && (cnt == CW'(BLK-1));
  assign two_q     = (h_q != 2'd0) && (v_q != 2'd0);
  assign ry        = cnt[RW-1:0];
  assign mid_sh    = (wgt(h_q) + wgt(v_q)) >> 1;
  assign mid_bias  = SUM_W'((1 << (mid_sh-1)) + int'(rnd_q) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_LOAD;
      cnt   <= '0;
      h_q   <= '0;
      v_q   <= '0;
      rnd_q <= 1'b0;
      avg_q <= 1'b0;
    end else begin
      case (st)
        S_LOAD: if (in_valid) begin
          if (cnt == '0) begin
            h_q   <= hmode;
            v_q   <= vmode;
            rnd_q <= rnd;
            avg_q <= avg_mode;
          end
          if (cnt == CW'(WIN-1)) begin
            cnt <= '0;
            st  <= two_q ? S_VERT : S_OUT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_VERT: if (cnt == CW'(BLK-1)) begin
          cnt <= '0;
          st  <= S_OUT;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: if (cnt == CW'(BLK-1)) begin
          cnt <= '0;
          st  <= S_LOAD;
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_LOAD && in_valid)
      for (int k = 0; k < WIN; k++) win[cnt][k] <= in_row[k*PIX_W +: PIX_W];
    if (st == S_VERT)
      for (int k = 0; k < WIN; k++) mid[ry][k] <= MID_W'(mval[k]);
  end

  always_comb begin
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < WIN; k++)
        vrow[t][k] = win[cnt + CW'(t)][k];
  end

  for (genvar k = 0; k < WIN; k++) begin : g_mid
    assign mval[k] = (fir4(v_q, SUM_W'(vrow[0][k]), SUM_W'(vrow[1][k]),
                           SUM_W'(vrow[2][k]), SUM_W'(vrow[3][k])) + mid_bias) >>> mid_sh;

    assert_mid_fit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_VERT) |-> (mval[k] <= SUM_W'(MID_MAX)) && (mval[k] >= SUM_W'(MID_MIN)));
  end

  for (genvar x = 0; x < BLK; x++) begin : g_col
    logic signed [SUM_W-1:0] acc, res;
    logic [PIX_W-1:0] clip, dpx;
    logic [PIX_W:0]   s9;

    assign dpx = dst_row[x*PIX_W +: PIX_W];

    always_comb begin
      if (two_q) begin
        acc = fir4(h_q, SUM_W'(mid[ry][x]), SUM_W'(mid[ry][x+1]),
                   SUM_W'(mid[ry][x+2]), SUM_W'(mid[ry][x+3]));
        res = (acc + SUM_W'(64 - int'(rnd_q))) >>> 7;
      end else if (h_q == 2'd0 && v_q != 2'd0) begin
        acc = fir4(v_q, SUM_W'(vrow[0][x+1]), SUM_W'(vrow[1][x+1]),
                   SUM_W'(vrow[2][x+1]), SUM_W'(vrow[3][x+1]));
        res = (acc + bias1(v_q, !rnd_q)) >>> sh1(v_q);
      end else begin
        acc = fir4(h_q, SUM_W'(vrow[1][x]), SUM_W'(vrow[1][x+1]),
                   SUM_W'(vrow[1][x+2]), SUM_W'(vrow[1][x+3]));
        res = (acc + bias1(h_q, rnd_q)) >>> sh1(h_q);
      end
      if (res < 0)                   clip = '0;
      else if (res > SUM_W'(PMAX))   clip = PIX_W'(PMAX);
      else                           clip = res[PIX_W-1:0];
      s9 = {1'b0, clip} + {1'b0, dpx} + {{PIX_W{1'b0}}, 1'b1};
    end

    assign out_row[x*PIX_W +: PIX_W] = avg_q ? s9[PIX_W:1] : clip;

    assert_avg_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && avg_q) |->
        (out_row[x*PIX_W +: PIX_W] >= ((clip < dpx) ? clip : dpx)) &&
        (out_row[x*PIX_W +: PIX_W] <= ((clip < dpx) ? dpx : clip)));
  end

  assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !done) |=> out_valid);

  assert_done_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (in_ready && !out_valid));

  assert_first_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && !two_q) |-> $past(in_valid && in_ready));

endmodule

// File: tb/qpel_bicubic_tb.sv
`timescale 1ns/1ps
module qpel_bicubic_tb;
  localparam int PW = 8, BLK = 8, WIN = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [WIN*PW-1:0] in_row = '0;
  logic [1:0] hmode = '0, vmode = '0;
  logic rnd = 1'b0, avg_mode = 1'b0;
  logic [BLK*PW-1:0] dst_row = '0;
  logic out_valid, done;
  logic [BLK*PW-1:0] out_row;

  int total = 0, bad = 0;
  int win [WIN][WIN];
  int dst [BLK][BLK];
  int midv [BLK][WIN];
  int expv [BLK][BLK];
  int rawv [BLK][BLK];

  always #2.5 clk = ~clk;

  qpel_bicubic u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .hmode(hmode), .vmode(vmode), .rnd(rnd), .avg_mode(avg_mode),
    .dst_row(dst_row), .out_valid(out_valid), .out_row(out_row), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int fsum(input int m, input int a, input int b, input int c, input int d);
    case (m)
      1: return -4*a + 53*b + 18*c - 3*d;
      2: return -a + 9*b + 9*c - d;
      3: return -3*a + 18*b + 53*c - 4*d;
      default: return 64*b;
    endcase
  endfunction

  function automatic int wgt(input int m);
    return (m == 1 || m == 3) ? 5 : (m == 2 ? 1 : 0);
  endfunction

  task automatic build_ref(input int h, input int v, input int r, input int a);
    int sh, bs;
    if (h != 0 && v != 0) begin
      sh = (wgt(h) + wgt(v)) >> 1;
      bs = (1 << (sh-1)) + r - 1;
      for (int y = 0; y < BLK; y++)
        for (int k = 0; k < WIN; k++)
          midv[y][k] = (fsum(v, win[y][k], win[y+1][k], win[y+2][k], win[y+3][k]) + bs) >>> sh;
    end
    for (int y = 0; y < BLK; y++)
      for (int x = 0; x < BLK; x++) begin
        int raw, c;
        if (h != 0 && v != 0)
          raw = (fsum(h, midv[y][x], midv[y][x+1], midv[y][x+2], midv[y][x+3]) + 64 - r) >>> 7;
        else if (h == 0 && v != 0)
          raw = (fsum(v, win[y][x+1], win[y+1][x+1], win[y+2][x+1], win[y+3][x+1])
                 + ((v == 2) ? 8 : 32) - (1 - r)) >>> ((v == 2) ? 4 : 6);
        else
          raw = (fsum(h, win[y+1][x], win[y+1][x+1], win[y+1][x+2], win[y+1][x+3])
                 + ((h == 2) ? 8 : 32) - r) >>> ((h == 2) ? 4 : 6);
        rawv[y][x] = raw;
        c = (raw < 0) ? 0 : ((raw > 255) ? 255 : raw);
        expv[y][x] = a ? ((c + dst[y][x] + 1) >> 1) : c;
      end
  endtask

  task automatic run_block(input int h, input int v, input int r, input int a,
                           input int pat, input bit gap, input bit junk);
    int k;
    string tag;
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < WIN; x++)
        case (pat)
          0: win[y][x] = $urandom_range(0, 255);
          1: win[y][x] = ((x + y) % 2 == 1) ? 255 : 0;
          2: win[y][x] = 255;
          default: win[y][x] = ($urandom_range(0, 1) == 1) ? 255 : $urandom_range(0, 40);
        endcase
    for (int y = 0; y < BLK; y++)
      for (int x = 0; x < BLK; x++) dst[y][x] = $urandom_range(0, 255);
    build_ref(h, v, r, a);

    if (h != 0 && v != 0) tag = "R7 R8";
    else if (h == 0 && v == 0) tag = "R11";
    else if (h == 2 || v == 2) tag = "R4 R6";
    else tag = "R5 R6";
    if (a) tag = {tag, " R10"};
    if (junk) tag = {tag, " R2"};

    for (int row = 0; row < WIN; row++) begin
      @(negedge clk);
      if (gap && row == 4) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      for (int x = 0; x < WIN; x++) in_row[x*PW +: PW] = PW'(win[row][x]);
      if (row == 0 || !junk) begin
        hmode = 2'(h); vmode = 2'(v); rnd = 1'(r); avg_mode = 1'(a);
      end else begin
        hmode = 2'(h ^ 3); vmode = 2'(v ^ 1); rnd = 1'(~r); avg_mode = 1'(~a);
      end
      chk(in_ready == 1'b1, "R1", int'(in_ready), 1, "in_ready while loading");
    end

    k = 0;
    do begin
      @(negedge clk);
      k++;
      in_valid = junk;
      in_row = {$urandom, $urandom, $urandom};
      if (!out_valid) chk(in_ready == 1'b0, "R1", int'(in_ready), 0, "in_ready while filtering");
    end while (!out_valid && k < 20);
    chk(k == ((h != 0 && v != 0) ? 9 : 1), "R3", k, (h != 0 && v != 0) ? 9 : 1, "first row latency");

    for (int y = 0; y < BLK; y++) begin
      for (int x = 0; x < BLK; x++) dst_row[x*PW +: PW] = PW'(dst[y][x]);
      #1;
      chk(out_valid == 1'b1, "R3", int'(out_valid), 1, "out_valid in burst");
      chk(done == (y == BLK-1), "R3", int'(done), int'(y == BLK-1), "done position");
      chk(in_ready == 1'b0, "R1", int'(in_ready), 0, "in_ready during output");
      for (int x = 0; x < BLK; x++) begin
        string t2;
        t2 = (rawv[y][x] < 0 || rawv[y][x] > 255) ? {tag, " R9"} : tag;
        chk(int'(out_row[x*PW +: PW]) == expv[y][x], t2, int'(out_row[x*PW +: PW]),
            expv[y][x], $sformatf("pixel h=%0d v=%0d r=%0d a=%0d y=%0d x=%0d", h, v, r, a, y, x));
      end
      if (y != BLK-1) @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R3", int'(in_ready), 1, "ready after done");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1, "reset in_ready");
    chk(out_valid == 1'b0, "R3", int'(out_valid), 0, "reset out_valid");
    chk(done == 1'b0, "R3", int'(done), 0, "reset done");
    for (int pat = 0; pat < 4; pat++)
      for (int h = 0; h < 4; h++)
        for (int v = 0; v < 4; v++)
          for (int r = 0; r < 2; r++)
            for (int a = 0; a < 2; a++)
              run_block(h, v, r, a, pat, ((h + v + pat) % 2) == 1, ((v + r + a) % 3) == 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule